// File: doc/BRIEF.md
# Memory Write-Protection Register Controller

This block guards the write path of a serial word memory. It keeps three pieces of nonvolatile state: a boundary address, a protection flag and a one-time lock bit. Every address from the boundary up to the top address is closed to programming while the flag reads 0. The serial command front end decodes each instruction and passes it in as a single commit event. That event carries the PRE and W pin levels, the two opcode bits, the address field, and an indication of whether the clock count was correct. The controller executes the instructions that read or modify the protection register, and clears the unlock marker on every other instruction.

The block also answers a combinational go/no-go query for the three programming requests: a single word, a page of up to four words, and the whole array. A readout shifter serialises the register for the read instruction. A status-enable output tells the front end whether it may show busy/ready on the data line.

Changes to the register are allowed only through a strict sequence. The write-enable state must already be set. An accepted enable instruction must come immediately before the single modifying instruction. Once the lock is set, the register can never be changed again.

Top module: `prot_ctrl`

## Requirements
- R1: With the flag at 0, a single-word query is refused for every address greater than or equal to the boundary and allowed below it. With the flag at 1, every single-word query is allowed.
- R2: The register-write instruction (PRE=1, opcode 01) loads the address field into the boundary and sets the flag to 0.
- R3: The register-clear instruction (PRE=1, opcode 11, address all ones) sets the boundary to all ones and the flag to 1. With opcode 11 and any other address, nothing changes.
- R4: The enable instruction (PRE=1, opcode 00, two top address bits 11) arms the unlock marker only when W=1, the write-enable state is 1 and the clock count is correct. It never changes the flag or the boundary.
- R5: Register-write, register-clear and lock take effect only when W=1, the clock count is correct, and the previous committed instruction armed the marker. Any other instruction, aborted ones included, disarms the marker.
- R6: The lock instruction (PRE=1, opcode 00, address all zeros) sets the lock bit. After that, no instruction changes the boundary, the flag or the lock.
- R7: After a register-read commit (PRE=1, opcode 10), the serial bit is 0. Each step pulse then presents the next bit: the boundary MSB first, then the flag.
- R8: A page query covers `chk_words` addresses (1 to 4). Each keeps the upper address bits and increments the low two bits modulo 4. The query is refused if any covered address is protected.
- R9: A whole-array query is allowed exactly when the flag is 1.
- R10: `status_show` is 0 while the lock bit is set and 1 otherwise.
- R11: Logic reset disarms the marker and empties the shifter, and keeps boundary, flag and lock. A factory clear restores boundary all ones, flag 1 and lock 0.
- R12: The verdict is computed from the register contents before the clock edge. A query made in the same cycle as a committed register-write uses the old boundary, and the new one applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low logic reset |
| factory_clr | input | 1 | Synchronous restore of nonvolatile defaults |
| ins_valid | input | 1 | One-cycle commit of a decoded instruction |
| ins_ok | input | 1 | Clock count of the instruction was correct |
| ins_pre | input | 1 | PRE pin level during the instruction |
| ins_w | input | 1 | W pin level during the instruction |
| ins_op | input | 2 | Opcode bits |
| ins_addr | input | AW | Address field |
| wen_state | input | 1 | Write-enable latch of the command interface |
| rd_step | input | 1 | Advance the readout by one bit |
| rd_bit | output | 1 | Current readout bit |
| chk_kind | input | 2 | Query: 0 none, 1 word, 2 page, 3 whole array |
| chk_addr | input | AW | Query start address |
| chk_words | input | PW+1 | Page word count |
| chk_allow | output | 1 | 1 when the queried programming may proceed |
| pr_bound | output | AW | Stored boundary address |
| pr_flag | output | 1 | Protection flag (1 means nothing protected) |
| pr_locked | output | 1 | One-time lock bit |
| status_show | output | 1 | Busy/ready may be presented |

## Verification
The register update and the verdict can fall in the same cycle. This happens when a query is held while a register-write commits. The bench arms the marker, then drives the write commit and a single-word query below the old boundary but above the new one in the same cycle. It samples the verdict before the edge, where the old boundary must allow the query, and again after the edge, where the new one must refuse it.

// File: rtl/prot_ctrl_pkg.sv
// Shared types for the write-protection register controller.
package prot_ctrl_pkg;

    // Kind of programming request presented for a verdict.
    typedef enum logic [1:0] {
        CHK_NONE = 2'b00,
        CHK_WORD = 2'b01,
        CHK_PAGE = 2'b10,
        CHK_ALL  = 2'b11
    } chk_kind_e;

    // Protection-register instruction classes after decoding.
    typedef enum logic [2:0] {
        INS_OTHER,
        INS_PRREAD,
        INS_PREN,
        INS_PRWRITE,
        INS_PRCLEAR,
        INS_PRDS
    } ins_cls_e;

    localparam logic [1:0] OPC_CTL = 2'b00;
    localparam logic [1:0] OPC_WR  = 2'b01;
    localparam logic [1:0] OPC_RD  = 2'b10;
    localparam logic [1:0] OPC_CLR = 2'b11;

endpackage

// File: rtl/prot_decode.sv
// Classifies a committed instruction into a protection-register class.
// Assumes: the opcode and address come from an already framed instruction.
module prot_decode
    import prot_ctrl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          pre,
    input  logic [1:0]    op,
    input  logic [AW-1:0] addr,
    output ins_cls_e      cls
);

    // Map the PRE level, opcode and address pattern to a class.
    always_comb begin
        cls = INS_OTHER;
        if (pre) begin
            case (op)
                OPC_RD:  cls = INS_PRREAD;
                OPC_WR:  cls = INS_PRWRITE;
                OPC_CLR: cls = (&addr) ? INS_PRCLEAR : INS_OTHER;
                default: begin
                    if (addr[AW-1:AW-2] == 2'b11)
                        cls = INS_PREN;
                    else if (addr == '0)
                        cls = INS_PRDS;
                    else
                        cls = INS_OTHER;
                end
            endcase
        end
    end

endmodule

// File: rtl/prot_regs.sv
// Holds boundary, flag and lock, plus the volatile unlock marker.
// Assumes: boundary, flag and lock are nonvolatile, so only factory_clr
// resets them; rst_n clears the marker only.
module prot_regs
    import prot_ctrl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          factory_clr,
    input  logic          ins_valid,
    input  logic          ins_ok,
    input  logic          ins_w,
    input  logic          wen_state,
    input  ins_cls_e      cls,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] bound,
    output logic          flag,
    output logic          locked,
    output logic          pren_seen
);

    logic pren_ok;
    logic mod_ok;

    // Enable is accepted with W high, write-enable set and a clean frame.
    assign pren_ok = (cls == INS_PREN) && ins_w && wen_state && ins_ok;
    // A modifying step needs the armed marker, W high, a clean frame, no lock.
    assign mod_ok  = pren_seen && ins_w && ins_ok && !locked;

    // Marker follows each committed instruction: armed only by an accepted enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pren_seen <= 1'b0;
        else if (ins_valid)
            pren_seen <= pren_ok;
    end

    // Nonvolatile state updates for write, clear and lock.
    always_ff @(posedge clk) begin
        if (factory_clr) begin
            bound  <= '1;
            flag   <= 1'b1;
            locked <= 1'b0;
        end else if (ins_valid && mod_ok) begin
            case (cls)
                INS_PRWRITE: begin
                    bound <= addr;
                    flag  <= 1'b0;
                end
                INS_PRCLEAR: begin
                    bound <= '1;
                    flag  <= 1'b1;
                end
                INS_PRDS: locked <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/prot_verdict.sv
// Combinational go/no-go for word, page and whole-array programming.
// Assumes: page addresses wrap within a page of 2**PW words.
module prot_verdict
    import prot_ctrl_pkg::*;
#(
    parameter int AW = 8,
    parameter int PW = 2
) (
    input  logic          flag,
    input  logic [AW-1:0] bound,
    input  chk_kind_e     kind,
    input  logic [AW-1:0] addr,
    input  logic [PW:0]   words,
    output logic          allow
);

    localparam int PAGE = 1 << PW;

    logic [PAGE-1:0] hit;
    logic            word_hit;

    // One comparator per page slot, enabled by the word count.
    for (genvar i = 0; i < PAGE; i++) begin : g_slot
        logic [AW-1:0] slot_addr;
        assign slot_addr = {addr[AW-1:PW], addr[PW-1:0] + PW'(i)};
        assign hit[i]    = (words > (PW+1)'(i)) && (slot_addr >= bound);
    end

    assign word_hit = (addr >= bound);

    // Select the verdict for the request kind.
    always_comb begin
        case (kind)
            CHK_WORD: allow = flag || !word_hit;
            CHK_PAGE: allow = flag || !(|hit);
            CHK_ALL:  allow = flag;
            default:  allow = 1'b0;
        endcase
    end

endmodule

// File: rtl/prot_readout.sv
// Serialises dummy 0, boundary MSB first, then flag.
// Assumes: a load and a step in the same cycle resolve to the load.
module prot_readout #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] bound,
    input  logic          flag,
    output logic          bit_out
);

    localparam int FW = AW + 2;

    logic [FW-1:0] frame;

    // Load the frame on a read commit; otherwise shift left on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame <= '0;
        else if (load)
            frame <= {1'b0, bound, flag};
        else if (step)
            frame <= {frame[FW-2:0], 1'b0};
    end

    assign bit_out = frame[FW-1];

endmodule

// File: rtl/prot_ctrl.sv
// Top of the write-protection register controller.
// Assumes: ins_valid pulses once per decoded instruction, and the query
// inputs are held stable for the cycle in which chk_allow is used.
module prot_ctrl
    import prot_ctrl_pkg::*;
#(
    parameter int AW = 8,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          factory_clr,
    input  logic          ins_valid,
    input  logic          ins_ok,
    input  logic          ins_pre,
    input  logic          ins_w,
    input  logic [1:0]    ins_op,
    input  logic [AW-1:0] ins_addr,
    input  logic          wen_state,
    input  logic          rd_step,
    output logic          rd_bit,
    input  logic [1:0]    chk_kind,
    input  logic [AW-1:0] chk_addr,
    input  logic [PW:0]   chk_words,
    output logic          chk_allow,
    output logic [AW-1:0] pr_bound,
    output logic          pr_flag,
    output logic          pr_locked,
    output logic          status_show
);

    ins_cls_e cls;
    logic     pren_seen;

    prot_decode #(.AW(AW)) u_dec (
        .pre  (ins_pre),
        .op   (ins_op),
        .addr (ins_addr),
        .cls  (cls)
    );

    prot_regs #(.AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .factory_clr (factory_clr),
        .ins_valid   (ins_valid),
        .ins_ok      (ins_ok),
        .ins_w       (ins_w),
        .wen_state   (wen_state),
        .cls         (cls),
        .addr        (ins_addr),
        .bound       (pr_bound),
        .flag        (pr_flag),
        .locked      (pr_locked),
        .pren_seen   (pren_seen)
    );

    prot_verdict #(.AW(AW), .PW(PW)) u_verdict (
        .flag  (pr_flag),
        .bound (pr_bound),
        .kind  (chk_kind_e'(chk_kind)),
        .addr  (chk_addr),
        .words (chk_words),
        .allow (chk_allow)
    );

    prot_readout #(.AW(AW)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ins_valid && (cls == INS_PRREAD)),
        .step    (rd_step),
        .bound   (pr_bound),
        .flag    (pr_flag),
        .bit_out (rd_bit)
    );

    // Busy/ready presentation is suppressed once the register is frozen.
    assign status_show = !pr_locked;

endmodule

// File: rtl/prot_ctrl_chk.sv
// Property checker for prot_ctrl, attached by bind.
module prot_ctrl_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          factory_clr,
    input logic          ins_valid,
    input logic          ins_pre,
    input logic [1:0]    ins_op,
    input logic          wen_state,
    input logic [AW-1:0] pr_bound,
    input logic          pr_flag,
    input logic          pr_locked,
    input logic          pren_seen,
    input logic [1:0]    chk_kind,
    input logic          chk_allow,
    input logic          rd_bit
);

    assert_flag_fall_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pr_flag) |-> $past(ins_valid && ins_pre && ins_op == 2'b01));

    assert_flag_rise_all_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pr_flag) |-> (pr_bound == {AW{1'b1}}));

    assert_marker_needs_wen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pren_seen) |-> $past(wen_state));

    assert_bound_needs_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pr_bound) && !$past(factory_clr)) |-> $past(pren_seen));

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_locked && !factory_clr) |=> pr_locked);

    assert_locked_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_locked && !factory_clr) |=> ($stable(pr_bound) && $stable(pr_flag)));

    assert_dummy_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && ins_valid && ins_pre && ins_op == 2'b10) |-> !rd_bit);

    assert_wral_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_kind == 2'b11 && !pr_flag) |-> !chk_allow);

endmodule

bind prot_ctrl prot_ctrl_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .factory_clr (factory_clr),
    .ins_valid   (ins_valid),
    .ins_pre     (ins_pre),
    .ins_op      (ins_op),
    .wen_state   (wen_state),
    .pr_bound    (pr_bound),
    .pr_flag     (pr_flag),
    .pr_locked   (pr_locked),
    .pren_seen   (pren_seen),
    .chk_kind    (chk_kind),
    .chk_allow   (chk_allow),
    .rd_bit      (rd_bit)
);

// File: tb/prot_ctrl_tb.sv
// Directed bench for prot_ctrl: one task per scenario.
module prot_ctrl_tb;

    localparam int AW = 8;
    localparam int PW = 2;
    localparam int FW = AW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          factory_clr = 1'b0;
    logic          ins_valid = 1'b0;
    logic          ins_ok = 1'b1;
    logic          ins_pre = 1'b0;
    logic          ins_w = 1'b0;
    logic [1:0]    ins_op = 2'b00;
    logic [AW-1:0] ins_addr = '0;
    logic          wen_state = 1'b1;
    logic          rd_step = 1'b0;
    logic          rd_bit;
    logic [1:0]    chk_kind = 2'b00;
    logic [AW-1:0] chk_addr = '0;
    logic [PW:0]   chk_words = '0;
    logic          chk_allow;
    logic [AW-1:0] pr_bound;
    logic          pr_flag;
    logic          pr_locked;
    logic          status_show;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    prot_ctrl #(.AW(AW), .PW(PW)) u_dut (.*);

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
            report();
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Commit one instruction for a single cycle; returns at the next negedge.
    task automatic cmd(logic pre, logic w, logic [1:0] op, logic [AW-1:0] a, logic ok);
        @(negedge clk);
        ins_pre = pre; ins_w = w; ins_op = op; ins_addr = a; ins_ok = ok;
        ins_valid = 1'b1;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic pren();
        cmd(1'b1, 1'b1, 2'b00, 8'hC0, 1'b1);
    endtask

    task automatic query(logic [1:0] k, logic [AW-1:0] a, int n, output logic allow);
        chk_kind = k; chk_addr = a; chk_words = (PW+1)'(n);
        #1;
        allow = chk_allow;
    endtask

    task automatic check_regs(string req, int b, int f, int l);
        check(req, int'(pr_bound), b);
        check(req, int'(pr_flag), f);
        check(req, int'(pr_locked), l);
    endtask

    task automatic t_reset_state();
        logic a;
        check_regs("R11 factory default", 'hFF, 1, 0);
        check("R10 status shown", int'(status_show), 1);
        query(2'b01, 8'hFF, 1, a); check("R1 flag1 top word", int'(a), 1);
        query(2'b11, 8'h00, 1, a); check("R9 all with flag1", int'(a), 1);
    endtask

    task automatic t_write_boundary();
        logic a;
        pren();
        cmd(1'b1, 1'b1, 2'b01, 8'h40, 1'b1);
        check_regs("R2 write loads", 'h40, 0, 0);
        query(2'b01, 8'h3F, 1, a); check("R1 below bound", int'(a), 1);
        query(2'b01, 8'h40, 1, a); check("R1 at bound", int'(a), 0);
        query(2'b01, 8'hFF, 1, a); check("R1 top", int'(a), 0);
        query(2'b11, 8'h00, 1, a); check("R9 all with flag0", int'(a), 0);
    endtask

    task automatic t_page();
        logic a;
        query(2'b10, 8'h3E, 4, a); check("R8 wrap 3E x4", int'(a), 1);
        query(2'b10, 8'h3F, 2, a); check("R8 wrap 3F x2", int'(a), 1);
        query(2'b10, 8'h7C, 1, a); check("R8 protected page", int'(a), 0);
        query(2'b10, 8'h3C, 0, a); check("R8 zero words", int'(a), 1);
    endtask

    task automatic t_enable_rules();
        wen_state = 1'b0;
        pren();
        cmd(1'b1, 1'b1, 2'b01, 8'h10, 1'b1);
        check_regs("R4 no wen", 'h40, 0, 0);
        wen_state = 1'b1;
        cmd(1'b1, 1'b0, 2'b00, 8'hC0, 1'b1);
        cmd(1'b1, 1'b1, 2'b01, 8'h10, 1'b1);
        check_regs("R4 enable with W low", 'h40, 0, 0);
        pren();
        check_regs("R4 enable keeps flag", 'h40, 0, 0);
    endtask

    task automatic t_ordering();
        pren();
        cmd(1'b0, 1'b1, 2'b10, 8'h05, 1'b1);
        cmd(1'b1, 1'b1, 2'b01, 8'h10, 1'b1);
        check_regs("R5 read between", 'h40, 0, 0);
        pren();
        cmd(1'b1, 1'b1, 2'b01, 8'h10, 1'b0);
        cmd(1'b1, 1'b1, 2'b01, 8'h10, 1'b1);
        check_regs("R5 aborted disarms", 'h40, 0, 0);
        pren();
        cmd(1'b1, 1'b0, 2'b01, 8'h10, 1'b1);
        check_regs("R5 W low on write", 'h40, 0, 0);
        pren();
        cmd(1'b1, 1'b1, 2'b01, 8'h20, 1'b1);
        check_regs("R5 direct sequence", 'h20, 0, 0);
    endtask

    task automatic t_clear();
        logic a;
        pren();
        cmd(1'b1, 1'b1, 2'b11, 8'hFE, 1'b1);
        check_regs("R3 partial ones", 'h20, 0, 0);
        pren();
        cmd(1'b1, 1'b1, 2'b11, 8'hFF, 1'b1);
        check_regs("R3 clear", 'hFF, 1, 0);
        query(2'b01, 8'hFF, 1, a); check("R3 nothing protected", int'(a), 1);
    endtask

    task automatic t_same_cycle();
        pren();
        cmd(1'b1, 1'b1, 2'b01, 8'hA5, 1'b1);
        pren();
        @(negedge clk);
        ins_pre = 1'b1; ins_w = 1'b1; ins_op = 2'b01; ins_addr = 8'h10; ins_ok = 1'b1;
        ins_valid = 1'b1;
        chk_kind = 2'b01; chk_addr = 8'h30;
        #1;
        check("R12 old bound before edge", int'(chk_allow), 1);
        @(negedge clk);
        ins_valid = 1'b0;
        check("R12 new bound after edge", int'(chk_allow), 0);
        check("R12 bound updated", int'(pr_bound), 'h10);
    endtask

    task automatic t_readout();
        logic [FW-1:0] exp_f;
        pren();
        cmd(1'b1, 1'b1, 2'b01, 8'hA5, 1'b1);
        exp_f = {1'b0, 8'hA5, 1'b0};
        cmd(1'b1, 1'b0, 2'b10, 8'h00, 1'b1);
        check("R7 dummy bit", int'(rd_bit), 0);
        rd_step = 1'b1;
        for (int j = 1; j < FW; j++) begin
            @(negedge clk);
            check("R7 frame bit", int'(rd_bit), int'(exp_f[FW-1-j]));
        end
        rd_step = 1'b0;
    endtask

    task automatic t_logic_reset();
        pren();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        check_regs("R11 reset keeps state", 'hA5, 0, 0);
        cmd(1'b1, 1'b1, 2'b01, 8'h33, 1'b1);
        check_regs("R11 reset disarms", 'hA5, 0, 0);
    endtask

    task automatic t_lock();
        logic a;
        pren();
        cmd(1'b1, 1'b1, 2'b00, 8'h00, 1'b1);
        check_regs("R6 lock set", 'hA5, 0, 1);
        check("R10 status hidden", int'(status_show), 0);
        pren();
        cmd(1'b1, 1'b1, 2'b11, 8'hFF, 1'b1);
        check_regs("R6 clear ignored", 'hA5, 0, 1);
        pren();
        cmd(1'b1, 1'b1, 2'b01, 8'h01, 1'b1);
        check_regs("R6 write ignored", 'hA5, 0, 1);
        query(2'b01, 8'hA4, 1, a); check("R1 verdict while locked", int'(a), 1);
    endtask

    task automatic t_factory();
        @(negedge clk); rst_n = 1'b0; factory_clr = 1'b1;
        @(negedge clk); factory_clr = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check_regs("R11 factory clear", 'hFF, 1, 0);
        check("R10 status back", int'(status_show), 1);
    endtask

    initial begin
        factory_clr = 1'b1;
        repeat (2) @(negedge clk);
        factory_clr = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_write_boundary();
        t_page();
        t_enable_rules();
        t_ordering();
        t_clear();
        t_same_cycle();
        t_readout();
        t_logic_reset();
        t_lock();
        t_factory();
        report();
    end

endmodule